// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block keeps a free-running microsecond count for a chip whose reference clock can be any of several frequencies, including ones that are not a whole number of megahertz. A software-visible ratio register holds two small fields, a dividend and a divisor. On every reference cycle a fractional accumulator adds the dividend. Each time the sum reaches the divisor, the block emits one microsecond tick, and that tick advances the counter.

Because the ratio is fractional, a 19.2 MHz reference averages exactly one tick per microsecond: five ticks are spread over every 96 reference cycles. Integer references such as 12, 13 or 26 MHz use a dividend of one. The counter wraps at its full width. A hold control can pause the counter and the accumulator together. All three registers sit on a simple single-cycle register bus. Reads are combinational from the address, and writes take effect on the clock edge where the write strobe is high.

Top module: `usec_timebase`

## Requirements
- R1: While reset is asserted, the counter at offset 0x10 reads 0, the ratio register at offset 0x14 reads 0x0000000B, and the hold register at offset 0x4C reads 0.
- R2: The ratio register bits [7:0] hold divisor−1 and bits [15:8] hold dividend−1. With dividend ≤ divisor, starting from a cleared accumulator, the counter advances by floor(N·dividend/divisor) over N running clock edges.
- R3: The ratio register reads back its written bits [15:0], and bits [31:16] read as 0.
- R4: A write to the ratio register leaves the counter unchanged on that edge and clears the accumulator, so counting restarts from a zero fraction.
- R5: While bit 0 of the hold register (offset 0x4C) is 1, the counter and the accumulator both keep their values. The register reads back that bit, with all other bits 0. After release, counting resumes with the stored fraction.
- R6: The counter wraps modulo 2^CNT_W, where CNT_W defaults to 32.
- R7: A write to the counter offset has no effect on the count.
- R8: A read of any address other than 0x10, 0x14 or 0x4C returns 0.
- R9: The counter advances by at most one per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (8) | Byte address of the register accessed |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |

## Verification
A wrong accumulator value does not show up at once. It appears at the counter as an increment that comes one or more edges early or late, at the first point where the expected floor sequence crosses an integer. For a ratio of 5/96 this can take up to about twenty edges, so each ratio is sampled on every edge over spans longer than one full ratio period. Errors in hold or ratio-load handling show up within one edge as a count that moves when it must not, or a fraction that restarts when it must be kept. Wrap errors are exposed by running a narrow counter through its top value.

// File: rtl/usec_pkg.sv
package usec_pkg;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned RATIO_W = 2 * FIELD_W;
    localparam int unsigned ACC_W   = FIELD_W + 1;
    localparam int unsigned SUM_W   = FIELD_W + 2;

    localparam logic [7:0] OFF_COUNT = 8'h10;
    localparam logic [7:0] OFF_RATIO = 8'h14;
    localparam logic [7:0] OFF_HOLD  = 8'h4C;

    typedef struct packed {
        logic [FIELD_W-1:0] dividend_m1;
        logic [FIELD_W-1:0] divisor_m1;
    } ratio_t;

    localparam ratio_t RATIO_RESET = ratio_t'(16'h000B);

    typedef struct packed {
        ratio_t ratio;
        logic   hold;
    } regs_t;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;
endpackage

// File: rtl/usec_regs.sv
module usec_regs
    import usec_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output ratio_t            ratio,
    output logic              hold,
    output logic              ratio_load
);
    regs_t st_d, st_q;
    logic  hit_count, hit_ratio, hit_hold;
    logic  unused_wdata_hi;

    assign hit_count = (addr == ADDR_W'(OFF_COUNT));
    assign hit_ratio = (addr == ADDR_W'(OFF_RATIO));
    assign hit_hold  = (addr == ADDR_W'(OFF_HOLD));
    assign unused_wdata_hi = ^wdata[DATA_W-1:RATIO_W];

    always_comb begin
        st_d       = st_q;
        ratio_load = 1'b0;
        if (wr_en && hit_ratio) begin
            st_d.ratio = ratio_t'(wdata[RATIO_W-1:0]);
            ratio_load = 1'b1;
        end
        if (wr_en && hit_hold) begin
            st_d.hold = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ratio: RATIO_RESET, hold: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_count) begin
            rdata[CNT_W-1:0] = count;
        end else if (hit_ratio) begin
            rdata[RATIO_W-1:0] = st_q.ratio;
        end else if (hit_hold) begin
            rdata[0] = st_q.hold;
        end
    end

    assign ratio = st_q.ratio;
    assign hold  = st_q.hold;
endmodule

// File: rtl/usec_frac_tick.sv
module usec_frac_tick
    import usec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ratio_t           ratio,
    input  logic             clear,
    input  logic             hold,
    output logic             tick,
    output logic [ACC_W-1:0] acc_level,
    output logic [ACC_W-1:0] dividend_val,
    output logic [ACC_W-1:0] divisor_val
);
    acc_state_t       st_d, st_q;
    logic [SUM_W-1:0] sum;

    assign dividend_val = ACC_W'(ratio.dividend_m1) + ACC_W'(1);
    assign divisor_val  = ACC_W'(ratio.divisor_m1) + ACC_W'(1);
    assign sum          = SUM_W'(st_q.acc) + SUM_W'(dividend_val);

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clear) begin
            st_d.acc = '0;
        end else if (!hold) begin
            if (sum >= SUM_W'(divisor_val)) begin
                st_d.acc = ACC_W'(sum - SUM_W'(divisor_val));
                tick     = 1'b1;
            end else begin
                st_d.acc = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_level = st_q.acc;
endmodule

// File: rtl/usec_count.sv
module usec_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc) begin
            st_d.value = st_q.value + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.value;
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import usec_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    ratio_t           ratio_val;
    logic             hold_on;
    logic             ratio_load;
    logic             usec_tick;
    logic [CNT_W-1:0] count_val;
    logic [ACC_W-1:0] acc_level;
    logic [ACC_W-1:0] dividend_val;
    logic [ACC_W-1:0] divisor_val;

    usec_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .count     (count_val),
        .rdata     (bus_rdata),
        .ratio     (ratio_val),
        .hold      (hold_on),
        .ratio_load(ratio_load)
    );

    usec_frac_tick u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio       (ratio_val),
        .clear       (ratio_load),
        .hold        (hold_on),
        .tick        (usec_tick),
        .acc_level   (acc_level),
        .dividend_val(dividend_val),
        .divisor_val (divisor_val)
    );

    usec_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (usec_tick),
        .value(count_val)
    );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk
    import usec_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ratio_load,
    input logic             hold,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] dividend,
    input logic [ACC_W-1:0] divisor
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (count == '0)); // R1

    AST_ACC_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (dividend <= divisor) |-> (acc < divisor)); // R2

    AST_LOAD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_load |=> ((count == $past(count)) && (acc == '0))); // R4

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !ratio_load) |=> ((count == $past(count)) && (acc == $past(acc)))); // R5

    AST_NO_TICK_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold || ratio_load) |-> !tick); // R5

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((count == $past(count)) || (count == CNT_W'($past(count) + CNT_W'(1))))); // R9
endmodule

bind usec_timebase usec_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_load(ratio_load),
    .hold      (hold_on),
    .tick      (usec_tick),
    .count     (count_val),
    .acc       (acc_level),
    .dividend  (dividend_val),
    .divisor   (divisor_val)
);

// File: tb/usec_timebase_test.sv
`timescale 1ns/100ps
module usec_timebase_test;
    localparam int unsigned CNT_W = 10;
    localparam int unsigned MASK  = (1 << CNT_W) - 1;
    localparam logic [7:0] A_CNT  = 8'h10;
    localparam logic [7:0] A_RAT  = 8'h14;
    localparam logic [7:0] A_HLD  = 8'h4C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = A_CNT;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    usec_timebase #(.ADDR_W(8), .DATA_W(32), .CNT_W(CNT_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
        bus_addr = A_CNT;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = A_CNT;
    endtask

    function automatic logic [31:0] expect_cnt(input int base, input int n, input int dd, input int dv);
        return 32'((base + (n * dd) / dv) & MASK);
    endfunction

    task automatic run_ratio(input logic [15:0] r, input int len, input string req);
        logic [31:0] v;
        int base;
        int dd;
        int dv;
        dd = int'(r[15:8]) + 1;
        dv = int'(r[7:0]) + 1;
        wr(A_RAT, {16'h0, r});
        rd(A_CNT, v);
        base = int'(v);
        for (int n = 1; n <= len; n++) begin
            @(negedge clk);
            rd(A_CNT, v);
            check(req, v, expect_cnt(base, n, dd, dv));
        end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        int m;

        // R1: values while reset is held
        repeat (3) @(negedge clk);
        rd(A_CNT, v); check("R1 count", v, 32'h0);
        rd(A_RAT, v); check("R1 ratio", v, 32'h0000000B);
        rd(A_HLD, v); check("R1 hold", v, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset ratio 1/12 from a cleared accumulator
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            rd(A_CNT, v);
            check("R2 reset ratio", v, expect_cnt(0, n, 1, 12));
        end

        // R2: reference ratios
        run_ratio(16'h000B, 120, "R2 12MHz");
        run_ratio(16'h000C, 120, "R2 13MHz");
        run_ratio(16'h0019, 120, "R2 26MHz");
        run_ratio(16'h045F, 300, "R2 19.2MHz");

        // R2: sweep of small dividend/divisor pairs
        for (int dd = 1; dd <= 8; dd++) begin
            for (int dv = dd; dv <= 8; dv++) begin
                run_ratio({8'(dd - 1), 8'(dv - 1)}, 24, "R2 sweep");
            end
        end

        // R6: one tick per edge runs the narrow counter through its wrap
        run_ratio(16'h0000, 1100, "R6 wrap");

        // R3: readback of ratio bits, upper bits zero
        wr(A_RAT, 32'hABCD045F);
        rd(A_RAT, v); check("R3 readback", v, 32'h0000045F);

        // R5: hold keeps count and fraction
        wr(A_RAT, 32'h0000045F);
        rd(A_CNT, v);
        base = int'(v);
        repeat (30) @(negedge clk);
        wr(A_HLD, 32'hFFFFFFFF);
        m = 31;
        rd(A_HLD, v); check("R5 hold readback", v, 32'h1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            rd(A_CNT, v);
            check("R5 held", v, expect_cnt(base, m, 5, 96));
        end
        wr(A_HLD, 32'h0);
        for (int n = 1; n <= 200; n++) begin
            @(negedge clk);
            rd(A_CNT, v);
            check("R5 resume", v, expect_cnt(base, m + n, 5, 96));
        end

        // R8: unmapped and cleared addresses
        rd(8'h20, v); check("R8 unmapped 0x20", v, 32'h0);
        rd(8'h00, v); check("R8 unmapped 0x00", v, 32'h0);
        rd(A_HLD, v); check("R5 hold cleared", v, 32'h0);

        // R4: ratio write keeps count and clears fraction
        repeat (50) @(negedge clk);
        rd(A_CNT, v);
        base = int'(v);
        wr(A_RAT, 32'h0000045F);
        rd(A_CNT, v); check("R4 count kept", v, 32'(base));
        for (int n = 1; n <= 120; n++) begin
            @(negedge clk);
            rd(A_CNT, v);
            check("R4 fraction cleared", v, expect_cnt(base, n, 5, 96));
        end

        // R7: write to the counter offset is ignored
        wr(A_RAT, 32'h00000203);
        rd(A_CNT, v);
        base = int'(v);
        repeat (5) @(negedge clk);
        wr(A_CNT, 32'h000003FF);
        rd(A_CNT, v); check("R7 after write", v, expect_cnt(base, 6, 3, 4));
        for (int n = 7; n <= 20; n++) begin
            @(negedge clk);
            rd(A_CNT, v);
            check("R7 continue", v, expect_cnt(base, n, 3, 4));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule